// File: doc/BRIEF.md
# Memory Data Bus Line Tester

The block is a small hardware sequencer that checks the data lines of a 64-bit memory bus for shorts between lines and for open lines. It drives a plain synchronous memory port and runs a fixed series of bit patterns through one word of memory. The patterns are built so that every pair of data lines is driven to opposite levels at least once, whatever the routing of those lines.

Each pattern is written to a target word, and then a fixed guard word is written to the next address. Only then is the target word read back, once. The guard write puts a different charge on the bus first, so a floating line cannot simply hold the written value and fake a pass. A line that is floating then returns bits of the guard value, which makes a dead byte lane easy to spot in the captured word.

Software or a boot sequencer pulses start with a base word address and waits for done. A sticky fail flag reports the result. The address, the expected word and the observed word of the first mismatch are held for diagnosis.

Top module: `dbus_line_tester`

## Requirements
- R1: Patterns are written to the base address in this order, each shown as the 64-bit hex value with bit 63 on the left: AAAAAAAAAAAAAAAA, CCCCCCCCCCCCCCCC, F0F0F0F0F0F0F0F0, FF00FF00FF00FF00, FFFF0000FFFF0000, FFFFFFFF00000000, 00000000FFFFFFFF, 0000FFFF0000FFFF, 00FF00FF00FF00FF, 0F0F0F0F0F0F0F0F, 3333333333333333, 5555555555555555.
- R2: The cycle after each pattern write, a write of the guard word 0123456789ABCDEF goes to base address plus one. The address wraps to zero from the top address.
- R3: The read request for the base address is issued only after that guard write. The compare waits for read-valid, so any read latency of one cycle or more works.
- R4: The base word is read exactly once per pattern, which gives 12 reads and 24 writes per run. The single captured word is used both for the compare and for the report.
- R5: A mismatch sets fail_o, which stays set. The run still goes through all remaining patterns.
- R6: The first mismatch latches the address, the expected word and the observed word into err_addr_o, err_exp_o and err_obs_o. Later mismatches leave them unchanged.
- R7: done_o stays high, with no memory strobes, until the next accepted start. A start pulse while busy_o is high is ignored.
- R8: After reset, busy_o, done_o, fail_o, mem_we_o and mem_re_o are all low.
- R9: An accepted start clears fail_o and the capture fields, and raises busy_o in the next cycle.
- R10: When a byte lane floats, the observed word holds the guard byte of that lane in place of the pattern byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| base_addr_i | input | ADDR_W | Word address under test |
| mem_addr_o | output | ADDR_W | Memory word address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_we_o | output | 1 | Memory write strobe |
| mem_re_o | output | 1 | Memory read request, one cycle |
| mem_rdata_i | input | DATA_W | Memory read data |
| mem_rvalid_i | input | 1 | Read data valid |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run finished, held until next start |
| fail_o | output | 1 | Sticky mismatch flag |
| err_addr_o | output | ADDR_W | Address of first mismatch |
| err_exp_o | output | DATA_W | Expected word of first mismatch |
| err_obs_o | output | DATA_W | Observed word of first mismatch |

## Verification
The bench builds the block with ADDR_W = 10 and DATA_W = 64, using the default guard word. The small address space puts the top word within reach, so the guard address wraps to zero. A memory model with a per-run read latency of 1 to 6 cycles exercises the wait for read-valid. The model can also force stuck-at bits, a floating byte lane or a wired-AND bridge between two lines, so that single and multiple mismatches occur and the first-fail capture can be checked.

// File: rtl/dbt_pkg.sv
package dbt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_PAT,
    ST_WR_GRD,
    ST_RD_REQ,
    ST_RD_WAIT,
    ST_DONE
  } dbt_state_e;

endpackage

// File: rtl/dbt_pattern_table.sv
module dbt_pattern_table #(
  parameter int DATA_W  = 64,
  parameter int NUM_PAT = 12,
  parameter int IDX_W   = 4
) (
  input  logic [IDX_W-1:0]  idx_i,
  output logic [DATA_W-1:0] pat_o
);
  localparam int HALF = NUM_PAT / 2;

  logic [DATA_W-1:0] tbl [NUM_PAT];

  // first half: bit b = bit k of b; second half mirrors it inverted
  for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
    localparam int K = (p < HALF) ? p : (NUM_PAT - 1 - p);
    localparam bit INV = (p >= HALF);
    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
      assign tbl[p][b] = (((b >> K) & 1) == 1) ^ INV;
    end
  end

  always_comb begin
    pat_o = '0;
    for (int i = 0; i < NUM_PAT; i++)
      if (idx_i == IDX_W'(i)) pat_o = tbl[i];
  end

endmodule

// File: rtl/dbt_sequencer.sv
module dbt_sequencer
  import dbt_pkg::*;
#(
  parameter int              ADDR_W  = 16,
  parameter int              DATA_W  = 64,
  parameter int              NUM_PAT = 12,
  parameter int              IDX_W   = 4,
  parameter logic [DATA_W-1:0] GUARD = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  input  logic [DATA_W-1:0] pat_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [ADDR_W-1:0] base_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic              mem_rvalid_i,
  output logic              cmp_en_o,
  output logic              clear_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_PAT - 1);

  dbt_state_e        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] base_q;
  logic              accept;

  assign accept = start_i && (st_q == ST_IDLE || st_q == ST_DONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      base_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE, ST_DONE: begin
          if (accept) begin
            base_q <= base_addr_i;
            idx_q  <= '0;
            st_q   <= ST_WR_PAT;
          end
        end
        ST_WR_PAT: st_q <= ST_WR_GRD;
        ST_WR_GRD: st_q <= ST_RD_REQ;
        ST_RD_REQ: st_q <= ST_RD_WAIT;
        ST_RD_WAIT: begin
          if (mem_rvalid_i) begin
            if (idx_q == LAST) begin
              st_q <= ST_DONE;
            end else begin
              idx_q <= idx_q + 1'b1;
              st_q  <= ST_WR_PAT;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign idx_o       = idx_q;
  assign base_o      = base_q;
  assign mem_we_o    = (st_q == ST_WR_PAT) || (st_q == ST_WR_GRD);
  assign mem_re_o    = (st_q == ST_RD_REQ);
  assign mem_addr_o  = (st_q == ST_WR_GRD) ? ADDR_W'(base_q + 1'b1) : base_q;
  assign mem_wdata_o = (st_q == ST_WR_GRD) ? GUARD : pat_i;
  assign cmp_en_o    = (st_q == ST_RD_WAIT) && mem_rvalid_i;
  assign clear_o     = accept;
  assign busy_o      = !(st_q == ST_IDLE || st_q == ST_DONE);
  assign done_o      = (st_q == ST_DONE);

  // R2
  guard_follows_pat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WR_PAT) |=> mem_we_o && mem_wdata_o == GUARD &&
                            mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1));

  // R3
  read_after_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |-> $past(mem_we_o) && $past(mem_wdata_o) == GUARD &&
                 mem_addr_o == ADDR_W'($past(mem_addr_o) - 1'b1));

  // R4
  single_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_re_o |=> !mem_re_o && !mem_we_o);

  // R7
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && !mem_we_o && !mem_re_o);

  // R7
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && start_i |=> $stable(base_q));

endmodule

// File: rtl/dbt_capture.sv
module dbt_capture #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              cmp_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic [DATA_W-1:0] obs_i,
  output logic              fail_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_obs_o
);
  logic mismatch;

  // obs_i is sampled only here, once per read
  assign mismatch = cmp_en_i && (obs_i != exp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_o     <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_obs_o  <= '0;
    end else if (clear_i) begin
      fail_o     <= 1'b0;
      err_addr_o <= '0;
      err_exp_o  <= '0;
      err_obs_o  <= '0;
    end else if (mismatch && !fail_o) begin
      fail_o     <= 1'b1;
      err_addr_o <= addr_i;
      err_exp_o  <= exp_i;
      err_obs_o  <= obs_i;
    end
  end

  // R5
  fail_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> fail_o);

  // R6
  capture_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o && !clear_i |=> $stable(err_addr_o) && $stable(err_exp_o) && $stable(err_obs_o));

  // R6
  first_capture_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmp_en_i && !fail_o && !clear_i && (obs_i != exp_i) |=> fail_o && err_obs_o == $past(obs_i));

endmodule

// File: rtl/dbus_line_tester.sv
module dbus_line_tester #(
  parameter int              ADDR_W = 16,
  parameter int              DATA_W = 64,
  parameter logic [DATA_W-1:0] GUARD = 64'h0123_4567_89AB_CDEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_addr_i,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic              mem_re_o,
  input  logic [DATA_W-1:0] mem_rdata_i,
  input  logic              mem_rvalid_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [ADDR_W-1:0] err_addr_o,
  output logic [DATA_W-1:0] err_exp_o,
  output logic [DATA_W-1:0] err_obs_o
);
  localparam int NUM_PAT = 2 * $clog2(DATA_W);
  localparam int IDX_W   = $clog2(NUM_PAT);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] pat;
  logic [ADDR_W-1:0] base;
  logic              cmp_en;
  logic              clear;

  dbt_pattern_table #(
    .DATA_W (DATA_W),
    .NUM_PAT(NUM_PAT),
    .IDX_W  (IDX_W)
  ) u_tbl (
    .idx_i(idx),
    .pat_o(pat)
  );

  dbt_sequencer #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NUM_PAT(NUM_PAT),
    .IDX_W  (IDX_W),
    .GUARD  (GUARD)
  ) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .base_addr_i (base_addr_i),
    .pat_i       (pat),
    .idx_o       (idx),
    .base_o      (base),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_we_o    (mem_we_o),
    .mem_re_o    (mem_re_o),
    .mem_rvalid_i(mem_rvalid_i),
    .cmp_en_o    (cmp_en),
    .clear_o     (clear),
    .busy_o      (busy_o),
    .done_o      (done_o)
  );

  dbt_capture #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_cap (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear),
    .cmp_en_i  (cmp_en),
    .addr_i    (base),
    .exp_i     (pat),
    .obs_i     (mem_rdata_i),
    .fail_o    (fail_o),
    .err_addr_o(err_addr_o),
    .err_exp_o (err_exp_o),
    .err_obs_o (err_obs_o)
  );

  // R8
  idle_after_reset_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(rst_ni) |-> !busy_o && !done_o && !fail_o);

endmodule

// File: tb/tb_dbus_line_tester.sv
module tb_dbus_line_tester;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 64;
  localparam logic [DW-1:0] GRD = 64'h0123_4567_89AB_CDEF;

  logic clk = 0, rst_n = 0, start = 0;
  logic [AW-1:0] base_in = '0;
  logic [AW-1:0] maddr;
  logic [DW-1:0] wdata, rdata;
  logic we, re, rvalid, busy, done, fail;
  logic [AW-1:0] e_addr;
  logic [DW-1:0] e_exp, e_obs;

  always #(CLK_PERIOD/2) clk = ~clk;

  dbus_line_tester #(.ADDR_W(AW), .DATA_W(DW), .GUARD(GRD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_addr_i(base_in),
    .mem_addr_o(maddr), .mem_wdata_o(wdata), .mem_we_o(we), .mem_re_o(re),
    .mem_rdata_i(rdata), .mem_rvalid_i(rvalid), .busy_o(busy), .done_o(done),
    .fail_o(fail), .err_addr_o(e_addr), .err_exp_o(e_exp), .err_obs_o(e_obs));

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] pat(input int n);
    case (n)
      0: pat = 64'hAAAAAAAAAAAAAAAA;  1: pat = 64'hCCCCCCCCCCCCCCCC;
      2: pat = 64'hF0F0F0F0F0F0F0F0;  3: pat = 64'hFF00FF00FF00FF00;
      4: pat = 64'hFFFF0000FFFF0000;  5: pat = 64'hFFFFFFFF00000000;
      6: pat = 64'h00000000FFFFFFFF;  7: pat = 64'h0000FFFF0000FFFF;
      8: pat = 64'h00FF00FF00FF00FF;  9: pat = 64'h0F0F0F0F0F0F0F0F;
      10: pat = 64'h3333333333333333; default: pat = 64'h5555555555555555;
    endcase
  endfunction

  // fault model
  logic [DW-1:0] s0_mask = '0, s1_mask = '0, fl_mask = '0;
  bit br_en = 0; int br_a = 0, br_b = 1;
  logic [DW-1:0] bus_last = '0;

  function automatic logic [DW-1:0] fault(input logic [DW-1:0] v, input logic [DW-1:0] bus);
    logic [DW-1:0] r;
    logic w;
    r = (v & ~fl_mask) | (bus & fl_mask);
    if (br_en) begin w = r[br_a] & r[br_b]; r[br_a] = w; r[br_b] = w; end
    r = (r & ~s0_mask) | s1_mask;
    return r;
  endfunction

  // memory model and bus monitor, both at negedge
  logic [DW-1:0] mem [1 << AW];
  int lat = 1, cnt = 0; bit pend = 0;
  logic [DW-1:0] held;
  logic [AW-1:0] base_exp = '0;
  int wr_cnt = 0, rd_cnt = 0; bit exp_grd = 0, grd_seen = 0;

  initial begin rvalid = 0; rdata = '0; end

  always @(negedge clk) begin
    cyc++;
    rvalid <= 1'b0;
    if (pend) begin
      if (cnt == 0) begin rvalid <= 1'b1; rdata <= held; pend = 0; end
      else cnt--;
    end
    if (rst_n) begin
      chk(!(we && re), "R4 no write and read together", {63'b0, we & re}, '0);
      if (we) begin
        if (!exp_grd) begin
          chk(maddr == base_exp, "R1 pattern address", DW'(maddr), DW'(base_exp));
          chk(wdata == pat(wr_cnt / 2), "R1 pattern order", wdata, pat(wr_cnt / 2));
          exp_grd = 1;
        end else begin
          chk(maddr == AW'(base_exp + 1), "R2 guard address", DW'(maddr), DW'(AW'(base_exp + 1)));
          chk(wdata == GRD, "R2 guard value", wdata, GRD);
          exp_grd = 0; grd_seen = 1;
        end
        mem[maddr] = wdata; bus_last = wdata; wr_cnt++;
      end
      if (re) begin
        chk(grd_seen && maddr == base_exp, "R3 read after guard", DW'(maddr), DW'(base_exp));
        held = fault(mem[maddr], bus_last);
        pend = 1; cnt = lat - 1; grd_seen = 0; rd_cnt++;
      end
    end
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  task automatic clear_faults();
    s0_mask = '0; s1_mask = '0; fl_mask = '0; br_en = 0;
  endtask

  task automatic run(input logic [AW-1:0] b, input int l, input bit mid_start);
    int first, k;
    logic [DW-1:0] o;
    lat = l;
    @(negedge clk);
    wr_cnt = 0; rd_cnt = 0; exp_grd = 0; grd_seen = 0; base_exp = b;
    base_in = b; start = 1;
    @(negedge clk);
    start = 0; base_in = ~b;
    chk(busy && !done && !fail, "R9 busy and cleared after start", {61'b0, busy, done, fail}, 64'h4);
    chk(e_obs == '0 && e_exp == '0, "R9 capture cleared", e_obs, '0);
    if (mid_start) begin
      repeat (5) @(negedge clk);
      start = 1;
      @(negedge clk);
      start = 0;
    end
    k = 0;
    while (!done && k < 2000) begin @(negedge clk); k++; end
    // expected outcome from the fault model
    first = -1;
    for (int n = 0; n < 12; n++) begin
      o = fault(pat(n), GRD);
      if (o != pat(n) && first < 0) first = n;
    end
    chk(done, "R7 done reached", {63'b0, done}, 64'h1);
    chk(rd_cnt == 12, "R4 read count", DW'(rd_cnt), 64'd12);
    chk(wr_cnt == 24, "R5 all patterns run", DW'(wr_cnt), 64'd24);
    chk(fail == (first >= 0), "R5 fail flag", {63'b0, fail}, {63'b0, first >= 0});
    if (first >= 0) begin
      chk(e_addr == b, "R6 error address", DW'(e_addr), DW'(b));
      chk(e_exp == pat(first), "R6 expected word", e_exp, pat(first));
      chk(e_obs == fault(pat(first), GRD), "R6 observed word", e_obs, fault(pat(first), GRD));
    end
    repeat (8) @(negedge clk);
    chk(done && !we && !re, "R7 done held idle", {62'b0, done, we | re}, 64'h2);
  endtask

  initial begin
    logic [AW-1:0] b;
    void'($urandom(32'd1234));
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !fail && !we && !re, "R8 reset state",
        {59'b0, busy, done, fail, we, re}, '0);
    rst_n = 1;
    @(negedge clk);
    chk(!busy && !done && !fail, "R8 idle after reset", {61'b0, busy, done, fail}, '0);

    // clean run, latency 1
    run(AW'($urandom), 1, 0);
    // clean run, long latency, start while busy ignored (R7)
    run(AW'($urandom), 6, 1);
    // top address: guard wraps to 0 (R2)
    run({AW{1'b1}}, 2, 0);

    // stuck-at-0 on a random bit (R5, R6)
    s0_mask = 64'd1 << ($urandom % 64);
    run(AW'($urandom), 3, 0);
    clear_faults();

    // floating byte lane 6 (R10)
    fl_mask = 64'h00FF_0000_0000_0000;
    run(AW'($urandom), 2, 0);
    chk(e_obs[55:48] == GRD[55:48], "R10 guard byte in failing lane", DW'(e_obs[55:48]), DW'(GRD[55:48]));
    chk(e_obs[63:56] == 8'hAA, "R10 healthy lane keeps pattern", DW'(e_obs[63:56]), 64'hAA);
    clear_faults();

    // restart clean after a failed run: fail cleared (R9)
    run(AW'($urandom), 1, 0);

    // bridge between adjacent bits: fails on pattern 0 (R1, R5)
    br_en = 1; br_a = 0; br_b = 1;
    run(AW'($urandom), 4, 0);
    clear_faults();

    // stuck-at-1 on a high bit: first fail later in the order (R6)
    s1_mask = 64'd1 << 63;
    run(AW'($urandom), 2, 0);
    clear_faults();

    // random fault mixes
    for (int t = 0; t < 6; t++) begin
      b = AW'($urandom);
      if ($urandom % 2) s0_mask = 64'd1 << ($urandom % 64);
      if ($urandom % 2) s1_mask = 64'd1 << ($urandom % 64);
      if ($urandom % 3 == 0) begin br_en = 1; br_a = $urandom % 64; br_b = $urandom % 64; end
      run(b, 1 + ($urandom % 6), ($urandom % 2) == 1);
      clear_faults();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule